// File: doc/BRIEF.md
# Punctured Code Acquisition Sequencer

This block hunts for decoder lock on a punctured convolutional stream when neither the code rate nor the puncture alignment is known in advance. It walks a fixed list of candidate conditions, each being one code rate with one puncture phase. For each candidate it drives the rate code and phase index to the depuncturer and decoder. It then holds that candidate for a programmable evaluation window and watches the decoder's lock flag. If the flag stays low for the whole window, the sequencer moves to the next candidate.

The list visits rate 3/4, then 2/3, 5/6, 7/8 and finally 1/2. This gives 26 candidates in all. Rate 1/2 contributes two entries because its symbol pairing has two possible alignments. When a full pass fails, the sequencer flips a 90-degree rotation select for the demodulated symbols and repeats the list, so a quarter-turn phase ambiguity is resolved without host action. Once lock is found, every output is frozen and the locked flag is raised. Lock is then supervised window by window: a programmable run of windows without lock sends the search back to its first candidate. One clock equals one symbol.

Top module: `punct_acq_seq`

## Requirements
- R1: After reset and until `start` is seen, `locked` is 0, `cond_idx` is 0, `rot90` is 0, `rate_code` is 2 and `phase_idx` is 0, and nothing advances.
- R2: `rate_code` uses 0=1/2, 1=2/3, 2=3/4, 3=5/6, 4=7/8. Candidates 0..3 are rate code 2 with phases 0..3. Candidates 4..9 are code 1 with phases 0..5. Candidates 10..15 are code 3 with phases 0..5. Candidates 16..23 are code 4 with phases 0..7. Candidates 24..25 are code 0 with phases 0..1.
- R3: While searching, each candidate is held for exactly `win_len` clocks. A `win_len` of 0 acts as 1.
- R4: When candidate 25's window ends without lock, `cond_idx` returns to 0 and `rot90` toggles. `rot90` changes at no other time during a search.
- R5: A high `dec_lock` on any searching clock, including the last clock of a window, sets `locked` on the next clock. While `locked` is 1, `cond_idx`, `rate_code`, `phase_idx` and `rot90` do not change.
- R6: While locked, a window with at least one high `dec_lock` clock clears the miss count. After `miss_limit` consecutive windows with no lock (0 acts as 1), `locked` drops and the search resumes at candidate 0 with `rot90` at 0.
- R7: `start` in any state restarts the search at candidate 0 with `rot90` at 0 and a fresh window.
- R8: `cond_idx` stays below 26, and `phase_idx` stays below the phase count of the current rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one symbol per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart the search |
| dec_lock | input | 1 | Decoder lock indication |
| win_len | input | WIN_W (16) | Evaluation window length in clocks |
| miss_limit | input | MISS_W (4) | Consecutive lock-free windows that end a lock |
| rate_code | output | 3 | Current code rate code |
| phase_idx | output | 3 | Current puncture phase |
| rot90 | output | 1 | 90-degree rotation select |
| locked | output | 1 | Lock held |
| cond_idx | output | 5 | Current candidate index |

## Verification
The assertions assume that `dec_lock` is synchronous to `clk`. They also assume that `win_len` changes only rarely, so that the window counter is checked only against a length that has held steady for a cycle. Lock entry and the freeze are checked against the `start` pin, so a restart may legitimately break either rule. The stimulus changes `win_len` and `miss_limit` only while a restart is pending, drives every input on the falling edge, and pulses `start` for one clock at a time.

// File: rtl/punct_acq_pkg.sv
package punct_acq_pkg;
  localparam int N_RATES = 5;
  localparam int RATE_W  = 3;
  localparam int PH_W    = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_LOCK   = 2'd2
  } acq_state_e;

  // puncture ambiguity count for a rate code
  function automatic int phases_of(int code);
    case (code)
      0:       return 2;
      1:       return 6;
      2:       return 4;
      3:       return 6;
      4:       return 8;
      default: return 1;
    endcase
  endfunction

  // rate code visited at a given position of the search order
  function automatic int rate_at(int pos);
    case (pos)
      0:       return 2;
      1:       return 1;
      2:       return 3;
      3:       return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int base_of(int pos);
    int b;
    b = 0;
    for (int i = 0; i < pos; i++) b += phases_of(rate_at(i));
    return b;
  endfunction

  localparam int N_COND = base_of(N_RATES);
  localparam int COND_W = $clog2(N_COND);
endpackage

// File: rtl/punct_cond_map.sv
module punct_cond_map
  import punct_acq_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  output logic [RATE_W-1:0] rate,
  output logic [PH_W-1:0]   phase
);
  logic [N_RATES-1:0] below_end;
  logic [N_RATES-1:0] hit;
  logic [PH_W-1:0]    ph_g [N_RATES];

  for (genvar g = 0; g < N_RATES; g++) begin : g_grp
    localparam int BASE = base_of(g);
    localparam int ENDP = base_of(g + 1);
    assign below_end[g] = {1'b0, cond} < (COND_W+1)'(ENDP);
    assign ph_g[g]      = PH_W'(cond - COND_W'(BASE));
    if (g == 0) begin : g_first
      assign hit[g] = below_end[g];
    end else begin : g_rest
      assign hit[g] = below_end[g] & ~below_end[g-1];
    end
  end

  always_comb begin
    rate  = '0;
    phase = '0;
    for (int i = 0; i < N_RATES; i++) begin
      if (hit[i]) begin
        rate  = RATE_W'(rate_at(i));
        phase = ph_g[i];
      end
    end
  end
endmodule

// File: rtl/punct_win_timer.sv
module punct_win_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [WIN_W-1:0] win_len,
  output logic             last
);
  logic [WIN_W-1:0] cnt;
  logic [WIN_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + (WIN_W+1)'(1);
  assign last    = cnt_inc >= {1'b0, win_len};

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || last)  cnt <= '0;
    else                   cnt <= cnt_inc[WIN_W-1:0];
  end

  // R3: the count never passes a steady window length
  a_r3_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len != '0 && $stable(win_len)) |-> cnt < win_len);
endmodule

// File: rtl/punct_acq_fsm.sv
module punct_acq_fsm
  import punct_acq_pkg::*;
#(
  parameter int MISS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dec_lock,
  input  logic              win_last,
  input  logic [MISS_W-1:0] miss_limit,
  output logic              timer_clr,
  output logic [COND_W-1:0] cond,
  output logic              rot,
  output logic              locked
);
  localparam logic [COND_W-1:0] LAST_COND = COND_W'(N_COND - 1);

  acq_state_e        state;
  logic [COND_W-1:0] cond_q;
  logic              rot_q;
  logic [MISS_W-1:0] miss_q;
  logic              seen_q;
  logic              seen_now;
  logic [MISS_W:0]   miss_inc;
  logic [MISS_W:0]   miss_lim;
  logic              lost;

  assign seen_now = seen_q | dec_lock;
  assign miss_inc = {1'b0, miss_q} + (MISS_W+1)'(1);
  assign miss_lim = (miss_limit == '0) ? (MISS_W+1)'(1) : {1'b0, miss_limit};
  assign lost     = miss_inc >= miss_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cond_q <= '0;
      rot_q  <= 1'b0;
      miss_q <= '0;
      seen_q <= 1'b0;
    end else if (start) begin
      state  <= ST_SEARCH;
      cond_q <= '0;
      rot_q  <= 1'b0;
      miss_q <= '0;
      seen_q <= 1'b0;
    end else begin
      case (state)
        ST_SEARCH: begin
          if (dec_lock) begin
            state  <= ST_LOCK;
            miss_q <= '0;
            seen_q <= 1'b0;
          end else if (win_last) begin
            if (cond_q == LAST_COND) begin
              cond_q <= '0;
              rot_q  <= ~rot_q;
            end else begin
              cond_q <= cond_q + COND_W'(1);
            end
          end
        end
        ST_LOCK: begin
          if (win_last) begin
            seen_q <= 1'b0;
            if (seen_now) begin
              miss_q <= '0;
            end else if (lost) begin
              state  <= ST_SEARCH;
              cond_q <= '0;
              rot_q  <= 1'b0;
              miss_q <= '0;
            end else begin
              miss_q <= miss_inc[MISS_W-1:0];
            end
          end else begin
            seen_q <= seen_now;
          end
        end
        default: ;
      endcase
    end
  end

  assign timer_clr = start | (state == ST_IDLE) | ((state == ST_SEARCH) & dec_lock);
  assign cond      = cond_q;
  assign rot       = rot_q;
  assign locked    = (state == ST_LOCK);

  // R1: idle persists until start
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> state == ST_IDLE);
  // R3: no step inside a window
  a_r3_hold_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEARCH && !win_last && !start) |=> $stable(cond_q));
  // R4: rotation flips only with a wrap to candidate 0
  a_r4_rot_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rot_q) |-> cond_q == '0);
  // R5: lock seen while searching is taken on the next clock
  a_r5_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEARCH && dec_lock && !start) |=> locked);
  // R5: frozen selection while locked
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> ($stable(cond_q) && $stable(rot_q)));
  // R6 and R7: leaving lock always lands on candidate 0, rotation 0
  a_r6_restart_point: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (cond_q == '0 && !rot_q));
endmodule

// File: rtl/punct_acq_seq.sv
module punct_acq_seq
  import punct_acq_pkg::*;
#(
  parameter int WIN_W  = 16,
  parameter int MISS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dec_lock,
  input  logic [WIN_W-1:0]  win_len,
  input  logic [MISS_W-1:0] miss_limit,
  output logic [RATE_W-1:0] rate_code,
  output logic [PH_W-1:0]   phase_idx,
  output logic              rot90,
  output logic              locked,
  output logic [COND_W-1:0] cond_idx
);
  logic timer_clr;
  logic win_last;

  punct_win_timer #(.WIN_W(WIN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (timer_clr),
    .win_len (win_len),
    .last    (win_last)
  );

  punct_acq_fsm #(.MISS_W(MISS_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dec_lock   (dec_lock),
    .win_last   (win_last),
    .miss_limit (miss_limit),
    .timer_clr  (timer_clr),
    .cond       (cond_idx),
    .rot        (rot90),
    .locked     (locked)
  );

  punct_cond_map u_map (
    .cond  (cond_idx),
    .rate  (rate_code),
    .phase (phase_idx)
  );

  // R8: candidate and phase ranges
  a_r8_cond_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cond_idx) < N_COND);
  a_r8_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase_idx) < phases_of(int'(rate_code)));
endmodule

// File: tb/punct_acq_seq_test.sv
module punct_acq_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        dec_lock;
  logic [15:0] win_len;
  logic [3:0]  miss_limit;
  logic [2:0]  rate_code;
  logic [2:0]  phase_idx;
  logic        rot90;
  logic        locked;
  logic [4:0]  cond_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected {rate code, phase} per candidate, R2
  localparam logic [5:0] EXP [26] = '{
    6'o20, 6'o21, 6'o22, 6'o23,
    6'o10, 6'o11, 6'o12, 6'o13, 6'o14, 6'o15,
    6'o30, 6'o31, 6'o32, 6'o33, 6'o34, 6'o35,
    6'o40, 6'o41, 6'o42, 6'o43, 6'o44, 6'o45, 6'o46, 6'o47,
    6'o00, 6'o01
  };

  always #10 clk = ~clk;

  punct_acq_seq uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dec_lock   (dec_lock),
    .win_len    (win_len),
    .miss_limit (miss_limit),
    .rate_code  (rate_code),
    .phase_idx  (phase_idx),
    .rot90      (rot90),
    .locked     (locked),
    .cond_idx   (cond_idx)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic kick();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; dec_lock = 1'b0;
    win_len = 16'd3; miss_limit = 4'd2;
    @(negedge clk);
    tick(3);
    // R1 reset state
    chk("R1", "locked", locked, 0);
    chk("R1", "cond", cond_idx, 0);
    chk("R1", "rot", rot90, 0);
    chk("R1", "rate", rate_code, 2);
    chk("R1", "phase", phase_idx, 0);
    rst_n = 1'b1;
    tick(5);
    chk("R1", "cond idle", cond_idx, 0);
    chk("R1", "locked idle", locked, 0);

    // table walk: R2 mapping, R3 window length
    kick();
    for (int k = 0; k < 26; k++) begin
      chk("R3", "cond at window start", cond_idx, k);
      chk("R2", "rate", rate_code, int'(EXP[k][5:3]));
      chk("R2", "phase", phase_idx, int'(EXP[k][2:0]));
      chk("R4", "rot first pass", rot90, 0);
      tick(2);
      chk("R3", "cond late in window", cond_idx, k);
      tick(1);
    end
    // R4 wrap with rotation
    chk("R4", "cond after wrap", cond_idx, 0);
    chk("R4", "rot after wrap", rot90, 1);
    tick(78);
    chk("R4", "cond second wrap", cond_idx, 0);
    chk("R4", "rot second wrap", rot90, 0);

    // R5 lock on the last clock of a window beats the step
    kick();
    tick(2);
    dec_lock = 1'b1;
    tick();
    chk("R5", "locked at window end", locked, 1);
    chk("R5", "cond at window end", cond_idx, 0);
    tick(10);
    chk("R5", "frozen cond", cond_idx, 0);
    chk("R5", "frozen rate", rate_code, 2);
    dec_lock = 1'b0;

    // R5 lock mid-list, then R6 loss after two empty windows
    kick();
    tick(16);
    dec_lock = 1'b1;
    tick();
    chk("R5", "locked mid list", locked, 1);
    chk("R5", "cond mid list", cond_idx, 5);
    chk("R5", "rate mid list", rate_code, 1);
    chk("R5", "phase mid list", phase_idx, 1);
    tick(3);
    dec_lock = 1'b0;
    tick(5);
    chk("R6", "still locked after one miss", locked, 1);
    chk("R6", "cond held", cond_idx, 5);
    tick(1);
    chk("R6", "unlocked after limit", locked, 0);
    chk("R6", "restart cond", cond_idx, 0);
    chk("R6", "restart rot", rot90, 0);

    // R6 a single lock clock clears the miss count
    kick();
    dec_lock = 1'b1;
    tick();
    dec_lock = 1'b0;
    tick(3);
    dec_lock = 1'b1;
    tick(1);
    dec_lock = 1'b0;
    tick(7);
    chk("R6", "miss count cleared", locked, 1);
    tick(1);
    chk("R6", "lost after fresh misses", locked, 0);

    // R7 start while locked
    kick();
    dec_lock = 1'b1;
    tick();
    chk("R7", "locked before restart", locked, 1);
    dec_lock = 1'b0;
    kick();
    chk("R7", "unlocked by start", locked, 0);
    chk("R7", "cond after start", cond_idx, 0);
    // R7 start mid-search gives a full fresh window
    tick(10);
    chk("R7", "searching cond", cond_idx, 3);
    kick();
    tick(2);
    chk("R7", "fresh window held", cond_idx, 0);
    tick(1);
    chk("R7", "fresh window ends", cond_idx, 1);

    // R3 zero window length acts as one
    win_len = 16'd0;
    kick();
    chk("R3", "zero window cond0", cond_idx, 0);
    tick(1);
    chk("R3", "zero window cond1", cond_idx, 1);
    tick(1);
    chk("R3", "zero window cond2", cond_idx, 2);

    // R6 zero miss limit acts as one
    win_len = 16'd3;
    miss_limit = 4'd0;
    kick();
    dec_lock = 1'b1;
    tick();
    dec_lock = 1'b0;
    tick(2);
    chk("R6", "limit0 still locked", locked, 1);
    tick(1);
    chk("R6", "limit0 lost", locked, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end
endmodule